// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block turns 32-bit device addresses into physical addresses for a bus master that sits behind it. Translation uses a single-level table held in memory: one 32-bit descriptor per 4 KiB page, indexed directly by the upper 20 address bits. A requester presents an address on the request port and receives either a physical address or a fault indication. On a miss in its small, fully associative translation cache, the block reads exactly one descriptor over a simple memory read port.

A register port lets software set the table base, a fault redirection address and the cache invalidation controls. Software can drop every cached translation at once. It can also drop only the pages that fall inside an inclusive window; a completion flag reports when that windowed walk has finished. While an invalidation is pending or running, new requests are held off. An access whose descriptor is not valid is answered with the programmed redirection address, so the faulting transfer lands in a harmless scratch area.

Top module: `iommu_flat_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` and `mem_req` are 0, and every register reads as 0.
- R2: A request that misses the cache causes exactly one descriptor read at address base + (iova[31:12] × 4), with base held at register address 0.
- R3: A valid descriptor yields `resp_pa` = {descriptor[31:12], iova[11:0]} with `resp_fault` 0, and a later request to the same page is answered with no memory read.
- R4: A descriptor whose bit 1 is 0 yields `resp_fault` 1 and `resp_pa` equal to the redirection register (address 6); such a page is not cached, so a repeat request reads memory again.
- R5: The redirection register (address 6) keeps only bits 31:7; bits 6:0 read as 0.
- R6: Writing 2 to the command register (address 4) while the select register (address 1) holds 1 in both bits 0 and 1 drops every cached translation and returns the replacement pointer to slot 0.
- R7: Writing 1 to the command register under the same select condition drops only cached pages whose number lies between start[31:12] (address 2) and end[31:12] (address 3) inclusive; bits 11:0 of start and end are ignored, and other pages stay cached.
- R8: The completion flag (address 5, bit 0) reads 1 once a windowed invalidation has finished; writing 0 to address 5 clears it.
- R9: A command written while the select register does not have both bits 0 and 1 set changes no cached translation and leaves the completion flag unchanged.
- R10: From the cycle after a command write until the invalidation is complete, `req_ready` is 0 and no descriptor read is in progress during the windowed walk.
- R11: The cache holds TLB_ENTRIES (default 8) translations filled in round-robin order, so the ninth distinct page filled after a full drop evicts the first while the third stays cached.
- R12: Each accepted request gets exactly one `resp_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_iova | input | 32 | Device address to translate |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_pa | output | 32 | Physical address, or redirection address on fault |
| resp_fault | output | 1 | Descriptor was not valid |
| mem_req | output | 1 | Descriptor read outstanding, held until mem_rvalid |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rvalid | input | 1 | Descriptor data returned |
| mem_rdata | input | 32 | Descriptor word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |

## Verification
The assertions take for granted that the table base and redirection registers are not rewritten while a translation is in flight, and that the memory side answers each read with a single `mem_rvalid` pulse while `mem_req` is held. The bench writes configuration only between translations, waits for each response before issuing the next request, and its memory model returns data one cycle after it sees a read, dropping `mem_rvalid` on the following edge. Descriptor contents come from a bench function of the page number and a generation value, so changing the generation shows whether a page was refetched after an invalidation.

// File: rtl/iommu_flat_pkg.sv
package iommu_flat_pkg;

  localparam int PAGE_SHIFT = 12;
  localparam int VPN_W      = 32 - PAGE_SHIFT;
  localparam int DESC_VALID = 1;

  localparam logic [2:0] RA_BASE  = 3'd0;
  localparam logic [2:0] RA_SEL   = 3'd1;
  localparam logic [2:0] RA_START = 3'd2;
  localparam logic [2:0] RA_END   = 3'd3;
  localparam logic [2:0] RA_CMD   = 3'd4;
  localparam logic [2:0] RA_DONE  = 3'd5;
  localparam logic [2:0] RA_PROT  = 3'd6;

  localparam logic [31:0] CMD_RANGE = 32'd1;
  localparam logic [31:0] CMD_ALL   = 32'd2;

  typedef enum logic [1:0] {W_IDLE, W_LOOK, W_FETCH} walk_st_e;

  function automatic logic [31:0] desc_addr(input logic [31:0] base,
                                            input logic [VPN_W-1:0] vpn);
    return base + {{(32-VPN_W-2){1'b0}}, vpn, 2'b00};
  endfunction

  function automatic logic [31:0] join_pa(input logic [VPN_W-1:0] pfn,
                                          input logic [PAGE_SHIFT-1:0] off);
    return {pfn, off};
  endfunction

  function automatic logic in_window(input logic [VPN_W-1:0] vpn,
                                     input logic [VPN_W-1:0] lo,
                                     input logic [VPN_W-1:0] hi);
    return (vpn >= lo) && (vpn <= hi);
  endfunction

endpackage

// File: rtl/iommu_flat_regs.sv
module iommu_flat_regs
  import iommu_flat_pkg::*;
#(
  parameter int PROT_ALIGN = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             inv_done,
  output logic [31:0]      rdata,
  output logic [31:0]      base_q,
  output logic [31:0]      prot_q,
  output logic [VPN_W-1:0] lo_vpn,
  output logic [VPN_W-1:0] hi_vpn,
  output logic             done_flag,
  output logic             cmd_all,
  output logic             cmd_range
);
  localparam logic [31:0] PROT_MASK = ~(32'(PROT_ALIGN) - 32'd1);

  logic [1:0]  sel_q;
  logic [31:0] start_q, end_q;
  logic        armed;

  assign armed     = (sel_q == 2'b11);
  assign cmd_all   = we && (addr == RA_CMD) && (wdata == CMD_ALL)   && armed;
  assign cmd_range = we && (addr == RA_CMD) && (wdata == CMD_RANGE) && armed;
  assign lo_vpn    = start_q[31:PAGE_SHIFT];
  assign hi_vpn    = end_q[31:PAGE_SHIFT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      prot_q    <= '0;
      sel_q     <= '0;
      start_q   <= '0;
      end_q     <= '0;
      done_flag <= 1'b0;
    end else begin
      if (we) begin
        case (addr)
          RA_BASE:  base_q  <= wdata;
          RA_SEL:   sel_q   <= wdata[1:0];
          RA_START: start_q <= wdata;
          RA_END:   end_q   <= wdata;
          RA_PROT:  prot_q  <= wdata & PROT_MASK;
          RA_DONE:  if (wdata == 32'd0) done_flag <= 1'b0;
          default:  ;
        endcase
      end
      if (inv_done) done_flag <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      RA_BASE:  rdata = base_q;
      RA_SEL:   rdata = {30'd0, sel_q};
      RA_START: rdata = start_q;
      RA_END:   rdata = end_q;
      RA_DONE:  rdata = {31'd0, done_flag};
      RA_PROT:  rdata = prot_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/iommu_flat_tlb.sv
module iommu_flat_tlb
  import iommu_flat_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lkp_vpn,
  output logic               hit,
  output logic [VPN_W-1:0]   hit_pfn,
  output logic [ENTRIES-1:0] hit_vec,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [VPN_W-1:0]   fill_pfn,
  input  logic               cmd_all,
  input  logic               cmd_range,
  input  logic [VPN_W-1:0]   lo_vpn,
  input  logic [VPN_W-1:0]   hi_vpn,
  input  logic               walker_idle,
  output logic               busy,
  output logic               inv_active,
  output logic               inv_done
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [VPN_W-1:0]   pfn_q [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr, walk_idx;
  logic [VPN_W-1:0]   lo_q, hi_q;
  logic               pend_all, pend_range, active, may_start;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = vld[i] && (tag_q[i] == lkp_vpn);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_pfn = hit_pfn | pfn_q[i];
  end

  assign busy       = pend_all || pend_range || active;
  assign inv_active = active;
  assign inv_done   = active && (walk_idx == LAST);
  assign may_start  = walker_idle && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld        <= '0;
      rr_ptr     <= '0;
      walk_idx   <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      pend_all   <= 1'b0;
      pend_range <= 1'b0;
      active     <= 1'b0;
    end else begin
      if (may_start && pend_all) begin
        vld      <= '0;
        rr_ptr   <= '0;
        pend_all <= 1'b0;
      end else if (may_start && pend_range) begin
        active     <= 1'b1;
        walk_idx   <= '0;
        pend_range <= 1'b0;
      end
      if (active) begin
        if (in_window(tag_q[walk_idx], lo_q, hi_q)) vld[walk_idx] <= 1'b0;
        walk_idx <= walk_idx + 1'b1;
        if (walk_idx == LAST) active <= 1'b0;
      end
      if (fill_en) begin
        vld[rr_ptr] <= 1'b1;
        rr_ptr      <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
      end
      if (cmd_all) pend_all <= 1'b1;
      if (cmd_range) begin
        pend_range <= 1'b1;
        lo_q       <= lo_vpn;
        hi_q       <= hi_vpn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[rr_ptr] <= fill_vpn;
      pfn_q[rr_ptr] <= fill_pfn;
    end
  end
endmodule

// File: rtl/iommu_flat_walk.sv
module iommu_flat_walk
  import iommu_flat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_iova,
  output logic             req_ready,
  output logic             resp_valid,
  output logic [31:0]      resp_pa,
  output logic             resp_fault,
  input  logic             tlb_busy,
  input  logic             hit,
  input  logic [VPN_W-1:0] hit_pfn,
  output logic [VPN_W-1:0] lkp_vpn,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [VPN_W-1:0] fill_pfn,
  input  logic [31:0]      base_q,
  input  logic [31:0]      prot_q,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             idle
);
  walk_st_e    st;
  logic [31:0] iova_q;
  logic        desc_ok;
  logic        unused_desc_bits;

  assign unused_desc_bits = ^{mem_rdata[PAGE_SHIFT-1:DESC_VALID+1], mem_rdata[DESC_VALID-1:0]};

  assign idle      = (st == W_IDLE);
  assign req_ready = idle && !tlb_busy;
  assign lkp_vpn   = iova_q[31:PAGE_SHIFT];
  assign mem_req   = (st == W_FETCH);
  assign mem_addr  = desc_addr(base_q, iova_q[31:PAGE_SHIFT]);
  assign desc_ok   = mem_rdata[DESC_VALID];
  assign fill_en   = mem_req && mem_rvalid && desc_ok;
  assign fill_vpn  = iova_q[31:PAGE_SHIFT];
  assign fill_pfn  = mem_rdata[31:PAGE_SHIFT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= W_IDLE;
      iova_q     <= '0;
      resp_valid <= 1'b0;
      resp_pa    <= '0;
      resp_fault <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        W_IDLE: if (req_valid && req_ready) begin
          iova_q <= req_iova;
          st     <= W_LOOK;
        end
        W_LOOK: if (hit) begin
          resp_valid <= 1'b1;
          resp_fault <= 1'b0;
          resp_pa    <= join_pa(hit_pfn, iova_q[PAGE_SHIFT-1:0]);
          st         <= W_IDLE;
        end else begin
          st <= W_FETCH;
        end
        W_FETCH: if (mem_rvalid) begin
          resp_valid <= 1'b1;
          resp_fault <= !desc_ok;
          resp_pa    <= desc_ok ? join_pa(fill_pfn, iova_q[PAGE_SHIFT-1:0]) : prot_q;
          st         <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iommu_flat_xlate.sv
module iommu_flat_xlate
  import iommu_flat_pkg::*;
#(
  parameter int TLB_ENTRIES = 8,
  parameter int PROT_ALIGN  = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_iova,
  output logic        req_ready,
  output logic        resp_valid,
  output logic [31:0] resp_pa,
  output logic        resp_fault,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  logic [31:0]            base_q, prot_q;
  logic [VPN_W-1:0]       lo_vpn, hi_vpn, lkp_vpn, hit_pfn, fill_vpn, fill_pfn;
  logic [TLB_ENTRIES-1:0] hit_vec;
  logic                   done_flag, cmd_all, cmd_range;
  logic                   hit, fill_en, tlb_busy, inv_active, inv_done, walker_idle;

  iommu_flat_regs #(.PROT_ALIGN(PROT_ALIGN)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .inv_done(inv_done), .rdata(reg_rdata), .base_q(base_q), .prot_q(prot_q),
    .lo_vpn(lo_vpn), .hi_vpn(hi_vpn), .done_flag(done_flag),
    .cmd_all(cmd_all), .cmd_range(cmd_range)
  );

  iommu_flat_tlb #(.ENTRIES(TLB_ENTRIES)) tlb_i (
    .clk(clk), .rst_n(rst_n), .lkp_vpn(lkp_vpn), .hit(hit), .hit_pfn(hit_pfn),
    .hit_vec(hit_vec), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .cmd_all(cmd_all), .cmd_range(cmd_range), .lo_vpn(lo_vpn), .hi_vpn(hi_vpn),
    .walker_idle(walker_idle), .busy(tlb_busy), .inv_active(inv_active),
    .inv_done(inv_done)
  );

  iommu_flat_walk walk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_iova(req_iova),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_pa(resp_pa),
    .resp_fault(resp_fault), .tlb_busy(tlb_busy), .hit(hit), .hit_pfn(hit_pfn),
    .lkp_vpn(lkp_vpn), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .base_q(base_q), .prot_q(prot_q), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .idle(walker_idle)
  );
endmodule

// File: rtl/iommu_flat_chk.sv
module iommu_flat_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               resp_valid,
  input logic               resp_fault,
  input logic [31:0]        resp_pa,
  input logic [31:0]        prot_q,
  input logic               mem_req,
  input logic               mem_rvalid,
  input logic [31:0]        mem_addr,
  input logic               inv_active,
  input logic               inv_done,
  input logic               done_flag,
  input logic [ENTRIES-1:0] hit_vec
);
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r4_fault_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_pa == prot_q));

  a_r2_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  a_r10_no_fetch_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_active |-> !mem_req);

  a_r8_flag_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |=> done_flag);

  a_r11_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

bind iommu_flat_xlate iommu_flat_chk #(.ENTRIES(TLB_ENTRIES)) chk_i (
  .clk(clk), .rst_n(rst_n), .resp_valid(resp_valid), .resp_fault(resp_fault),
  .resp_pa(resp_pa), .prot_q(prot_q), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .mem_addr(mem_addr), .inv_active(inv_active), .inv_done(inv_done),
  .done_flag(done_flag), .hit_vec(hit_vec)
);

// File: tb/iommu_flat_xlate_tb_top.sv
`timescale 1ns/1ps
module iommu_flat_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_iova = '0;
  logic        req_ready, resp_valid, resp_fault, mem_req;
  logic [31:0] resp_pa, mem_addr, reg_rdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;

  int          checks = 0;
  int          errors = 0;
  int          rd_cnt = 0;
  logic [31:0] last_addr = '0;
  logic [31:0] tb_base = 32'h8000_0000;
  logic [19:0] gen = '0;
  bit          finished = 0;

  localparam logic [31:0] PROT_IN  = 32'h1234_56FF;
  localparam logic [31:0] PROT_EXP = 32'h1234_5680;

  always #5 clk = ~clk;

  iommu_flat_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_iova(req_iova),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_pa(resp_pa),
    .resp_fault(resp_fault), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Descriptor model: pages with number bit 4 set are invalid (bit 1 clear).
  function automatic logic [31:0] model_desc(input logic [31:0] a);
    logic [19:0] v;
    v = 20'((a - tb_base) >> 2);
    if (v[4]) return {v, 12'h008};
    return {v ^ 20'h5A5A5 ^ gen, 12'h00A};
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] iova);
    return {iova[31:12] ^ 20'h5A5A5 ^ gen, iova[11:0]};
  endfunction

  always @(posedge clk) begin
    if (mem_rvalid) begin
      rd_cnt    = rd_cnt + 1;
      last_addr = mem_addr;
    end
    mem_rvalid <= mem_req && !mem_rvalid;
    mem_rdata  <= model_desc(mem_addr);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic translate(input logic [31:0] iova, output logic [31:0] pa,
                           output logic fault, output int reads);
    int start;
    bit got;
    start = rd_cnt;
    got = 0;
    @(negedge clk);
    req_valid = 1'b1; req_iova = iova;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 100 && !got; i++) begin
      if (resp_valid) begin
        got = 1; pa = resp_pa; fault = resp_fault;
      end else @(negedge clk);
    end
    chk("R12 response seen", 32'(got), 32'd1);
    @(negedge clk);
    chk("R12 strobe one cycle", 32'(resp_valid), 32'd0);
    reads = rd_cnt - start;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 resp_valid", 32'(resp_valid), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    rd_reg(3'd5, d); chk("R1 flag reg", d, 32'd0);
    rd_reg(3'd6, d); chk("R1 redirect reg", d, 32'd0);
    rd_reg(3'd0, d); chk("R1 base reg", d, 32'd0);
  endtask

  task automatic t_setup;
    logic [31:0] d;
    wr_reg(3'd0, tb_base);
    wr_reg(3'd1, 32'd3);
    wr_reg(3'd6, PROT_IN);
    rd_reg(3'd6, d); chk("R5 redirect low bits", d, PROT_EXP);
  endtask

  task automatic t_miss_hit;
    logic [31:0] pa; logic f; int n;
    translate(32'h0000_3ABC, pa, f, n);
    chk("R2 one read on miss", 32'(n), 32'd1);
    chk("R2 descriptor address", last_addr, tb_base + 32'd12);
    chk("R3 translated pa", pa, exp_pa(32'h0000_3ABC));
    chk("R3 no fault", 32'(f), 32'd0);
    translate(32'h0000_3001, pa, f, n);
    chk("R3 hit needs no read", 32'(n), 32'd0);
    chk("R3 hit pa", pa, exp_pa(32'h0000_3001));
  endtask

  task automatic t_fault;
    logic [31:0] pa; logic f; int n;
    translate(32'h0001_0123, pa, f, n);
    chk("R4 fault flag", 32'(f), 32'd1);
    chk("R4 redirected pa", pa, PROT_EXP);
    translate(32'h0001_0456, pa, f, n);
    chk("R4 fault not cached", 32'(n), 32'd1);
  endtask

  task automatic t_flush_all;
    logic [31:0] pa; logic f; int n;
    gen = 20'h00001;
    wr_reg(3'd4, 32'd2);
    chk("R10 stalled after command", 32'(req_ready), 32'd0);
    translate(32'h0000_3ABC, pa, f, n);
    chk("R6 refetch after drop", 32'(n), 32'd1);
    chk("R6 new pa after drop", pa, exp_pa(32'h0000_3ABC));
  endtask

  task automatic t_range;
    logic [31:0] pa, d; logic f; int n; bit seen_busy;
    for (int p = 32'h20; p <= 32'h23; p++) translate(32'(p) << 12, pa, f, n);
    gen = 20'h00002;
    wr_reg(3'd2, 32'h0002_1FFF);
    wr_reg(3'd3, 32'h0002_2001);
    wr_reg(3'd4, 32'd1);
    seen_busy = !req_ready;
    chk("R10 stalled during window walk", 32'(seen_busy), 32'd1);
    d = '0;
    for (int i = 0; i < 50 && d == 0; i++) begin
      @(negedge clk); rd_reg(3'd5, d);
    end
    chk("R8 completion flag set", d, 32'd1);
    translate(32'h0002_0010, pa, f, n);
    chk("R7 below window kept", 32'(n), 32'd0);
    gen = 20'h00001;
    chk("R7 below window old pa", pa, exp_pa(32'h0002_0010));
    gen = 20'h00002;
    translate(32'h0002_1010, pa, f, n);
    chk("R7 window start dropped", 32'(n), 32'd1);
    chk("R7 refetched pa", pa, exp_pa(32'h0002_1010));
    translate(32'h0002_2010, pa, f, n);
    chk("R7 window end dropped", 32'(n), 32'd1);
    translate(32'h0002_3010, pa, f, n);
    chk("R7 above window kept", 32'(n), 32'd0);
    wr_reg(3'd5, 32'd0);
    rd_reg(3'd5, d); chk("R8 flag cleared by zero", d, 32'd0);
  endtask

  task automatic t_select;
    logic [31:0] pa, d; logic f; int n;
    wr_reg(3'd1, 32'd1);
    wr_reg(3'd4, 32'd2);
    wr_reg(3'd4, 32'd1);
    repeat (20) @(negedge clk);
    translate(32'h0002_3020, pa, f, n);
    chk("R9 disarmed drop ignored", 32'(n), 32'd0);
    rd_reg(3'd5, d); chk("R9 flag unchanged", d, 32'd0);
    wr_reg(3'd1, 32'd3);
  endtask

  task automatic t_round_robin;
    logic [31:0] pa; logic f; int n;
    wr_reg(3'd4, 32'd2);
    for (int p = 32'h40; p <= 32'h48; p++) translate(32'(p) << 12, pa, f, n);
    translate(32'h0004_2000, pa, f, n);
    chk("R11 third page still cached", 32'(n), 32'd0);
    translate(32'h0004_0000, pa, f, n);
    chk("R11 first page evicted", 32'(n), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=expired expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_miss_hit();
    t_fault();
    t_flush_all();
    t_range();
    t_select();
    t_round_robin();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule